// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel that generates two pulse-width waveforms from one up-counter. The counter runs from one of four prescaled versions of the main clock or from an external slow-clock strobe. It counts up and returns to zero after it reaches a shared period register, so both outputs have the same period. Each output has its own compare register. Its edges come from three programmable actions: one for its own compare match, one for the period match and one for a software trigger. Each action can do nothing, set, clear or toggle the output.

Software drives the channel through a single-cycle register bus. It writes a mode word, three compare registers and a write-only command word. The command word starts and stops the counting clock and issues the software trigger. The trigger restarts the count and forces each output to a known level. Normal-polarity PWM uses set on period and clear on compare. Inverted PWM uses the opposite pair. A constant output for duty 0 or 100% comes from giving only the trigger action and leaving the compare actions at none.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset the counter reads 0, both outputs are 0, the counting clock is stopped, and the mode and compare registers read 0.
- R2: Mode bits [2:0] pick the count source. Codes 0, 1, 2 and 3 advance the counter once every 2, 8, 32 and 128 main-clock cycles, counted from the last software trigger. Code 4 advances it once per `slow_tick` strobe. Codes 5 to 7 never advance it.
- R3: On a count step taken while the counter equals the period register (address 3), the counter becomes 0. On any other count step it increments by one. The period is therefore period+1 steps.
- R4: Output A takes its compare-match action from mode bits [5:4], its period action from [7:6] and its trigger action from [9:8]. Output B uses bits [11:10], [13:12] and [15:14] in the same order, with its own compare register. Each action field encodes 0 = none, 1 = set, 2 = clear, 3 = toggle.
- R5: A command write (address 4) with bit 2 set does three things at the edge of the write: it zeroes the counter, restarts the prescaler phase and applies each output's trigger action.
- R6: An output whose actions for the events that occur are all none keeps its level.
- R7: After a command write with bit 1 (clock disable), the counter and outputs hold their values until bit 0 (clock enable) is written.
- R8: A command write with both bit 0 and bit 1 set leaves the clock stopped.
- R9: When the compare match and the period match occur on the same count step, the period action is applied after the compare action. A software trigger action is applied after both.
- R10: Addresses 0 to 3 read back mode, compare A, compare B and period exactly as written. Address 5 reads the live counter. Address 4 reads 0.
- R11: With compare action clear, period action set and trigger action set, an output is high exactly while the counter is at or below its compare value (compare below period). The inverted action set gives the complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle slow-clock strobe, main clock domain |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
The bench builds the channel with its default 16-bit counter. It keeps periods short, at 3 and 6 steps, so that all four prescale codes can be swept. The sweep covers every compare value below each period and runs several full periods per case, which keeps even the divide-by-128 case short. Small compare and period values let the bench check every cycle against a counter and duty level computed from the cycle count since the trigger. They also make the compare-equals-period collision, the wrap step and the command priority cases easy to reach.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_SET    = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  localparam int ADDR_W  = 3;
  localparam int MODE_W  = 16;
  localparam int SEL_W   = 3;
  localparam int NUM_DIV = 4;
  // largest divider is 2^(2*(NUM_DIV-1)+1)
  localparam int PRE_W   = 2 * (NUM_DIV - 1) + 1;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd2;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;

  localparam logic [SEL_W-1:0] SEL_SLOW = 3'd4;

  localparam int CMD_EN  = 0;
  localparam int CMD_DIS = 1;
  localparam int CMD_TRG = 2;

  // apply one action to an output level
  function automatic logic act_apply(input act_e a, input logic cur);
    case (a)
      ACT_SET:    act_apply = 1'b1;
      ACT_CLEAR:  act_apply = 1'b0;
      ACT_TOGGLE: act_apply = ~cur;
      default:    act_apply = cur;
    endcase
  endfunction

  // phase mask for a prescale code: divider 2^(2*sel+1) minus one
  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] one_hot;
    one_hot  = '0;
    one_hot[2 * int'(sel) + 1] = 1'b1;
    div_mask = PRE_W'(one_hot - 1'b1);
  endfunction

endpackage

// File: rtl/wtc_prescaler.sv
module wtc_prescaler
  import wtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic             slow_tick,
  output logic             tick
);

  logic [PRE_W-1:0] phase_q;
  logic             src_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    if (sel < SEL_W'(NUM_DIV))
      src_tick = (phase_q & div_mask(sel)) == div_mask(sel);
    else if (sel == SEL_SLOW)
      src_tick = slow_tick;
    else
      src_tick = 1'b0;
  end

  assign tick = run & src_tick & ~restart;

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick) else $error("tick while stopped"); // R7

endmodule

// File: rtl/wtc_counter.sv
module wtc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_a,
  output logic             hit_b,
  output logic             hit_per
);

  logic [CNT_W-1:0] cnt_q;

  assign hit_a   = tick & (cnt_q == cmp_a);
  assign hit_b   = tick & (cnt_q == cmp_b);
  assign hit_per = tick & (cnt_q == per);
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= hit_per ? '0 : cnt_q + 1'b1;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == per) |=> cnt_q == '0) else $error("no wrap"); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != per && !restart) |=> cnt_q == $past(cnt_q) + 1'b1) else $error("bad step"); // R3
  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0) else $error("trigger did not zero"); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q)) else $error("count moved"); // R7

endmodule

// File: rtl/wtc_output.sv
module wtc_output
  import wtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_hit,
  input  logic per_hit,
  input  logic trig,
  input  act_e act_cmp,
  input  act_e act_per,
  input  act_e act_sw,
  output logic level
);

  logic lvl_q;
  logic after_cmp, after_per, lvl_d;

  // order: compare, then period, then software trigger
  always_comb begin
    after_cmp = cmp_hit ? act_apply(act_cmp, lvl_q)     : lvl_q;
    after_per = per_hit ? act_apply(act_per, after_cmp) : after_cmp;
    lvl_d     = trig    ? act_apply(act_sw, after_per)  : after_per;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign level = lvl_q;

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_hit || per_hit || trig) |=> $stable(lvl_q)) else $error("level moved"); // R6
  AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && act_sw == ACT_SET) |=> lvl_q) else $error("set not applied"); // R4
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && act_sw == ACT_CLEAR) |=> !lvl_q) else $error("clear not applied"); // R4
  AST_PER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (per_hit && !trig && act_per == ACT_CLEAR) |=> !lvl_q) else $error("period action not last"); // R9

endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              out_a,
  output logic              out_b
);

  localparam int NUM_OUT = 2;

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cmpa_q, cmpb_q, per_q;
  logic              run_q;

  logic              cmd_wr, trig, tick;
  logic [CNT_W-1:0]  cnt;
  logic              hit_a, hit_b, hit_per;
  logic [NUM_OUT-1:0] cmp_hits, levels;

  assign cmd_wr = bus_wr && (bus_addr == A_CMD);
  assign trig   = cmd_wr && bus_wdata[CMD_TRG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      per_q  <= '0;
      run_q  <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE: mode_q <= bus_wdata[MODE_W-1:0];
        A_CMPA: cmpa_q <= bus_wdata;
        A_CMPB: cmpb_q <= bus_wdata;
        A_PER:  per_q  <= bus_wdata;
        A_CMD: begin
          if (bus_wdata[CMD_DIS])     run_q <= 1'b0;
          else if (bus_wdata[CMD_EN]) run_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata[MODE_W-1:0] = mode_q;
      A_CMPA:  bus_rdata = cmpa_q;
      A_CMPB:  bus_rdata = cmpb_q;
      A_PER:   bus_rdata = per_q;
      A_CNT:   bus_rdata = cnt;
      default: bus_rdata = '0;
    endcase
  end

  wtc_prescaler u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (trig),
    .run       (run_q),
    .sel       (mode_q[SEL_W-1:0]),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  wtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (trig),
    .cmp_a   (cmpa_q),
    .cmp_b   (cmpb_q),
    .per     (per_q),
    .cnt     (cnt),
    .hit_a   (hit_a),
    .hit_b   (hit_b),
    .hit_per (hit_per)
  );

  assign cmp_hits = {hit_b, hit_a};

  // output i uses mode bits [4+6i +: 6]: compare, period, trigger actions
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    localparam int BASE = 4 + 6 * i;
    wtc_output u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_hit (cmp_hits[i]),
      .per_hit (hit_per),
      .trig    (trig),
      .act_cmp (act_e'(mode_q[BASE +: 2])),
      .act_per (act_e'(mode_q[BASE + 2 +: 2])),
      .act_sw  (act_e'(mode_q[BASE + 4 +: 2])),
      .level   (levels[i])
    );
  end

  assign out_a = levels[0];
  assign out_b = levels[1];

  AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[CMD_DIS]) |=> !run_q) else $error("disable lost"); // R8
  AST_EN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[CMD_EN] && !bus_wdata[CMD_DIS]) |=> run_q) else $error("enable lost"); // R7
  AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(run_q)) else $error("run changed"); // R7

endmodule

// File: tb/wave_timer_chan_test.sv
`timescale 1ns/1ps
module wave_timer_chan_test;
  localparam int W = 16;

  logic clk = 0, rst_n = 0, slow_tick = 0, bus_wr = 0;
  logic [2:0] bus_addr = 3'd5;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic out_a, out_b;
  int tests = 0, fails = 0;
  int cyc = 0;

  wave_timer_chan #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .out_a(out_a), .out_b(out_b)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++; tests++;
      $display("FAIL watchdog: act=%0d exp<%0d", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    bus_wr = 1; bus_addr = a; bus_wdata = W'(d);
    @(posedge clk); #1;
    bus_wr = 0; bus_addr = 3'd5;
  endtask

  function automatic int mode_word(input int sel, input int acmp, input int aper,
                                   input int asw, input int bcmp, input int bper,
                                   input int bsw);
    return sel | (acmp << 4) | (aper << 6) | (asw << 8) |
           (bcmp << 10) | (bper << 12) | (bsw << 14);
  endfunction

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); bus_addr = a; #1; v = int'(bus_rdata); bus_addr = 3'd5;
  endtask

  initial begin
    int v, hold_c, hold_a, hold_b, prev_b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 counter", int'(bus_rdata), 0);
    chk("R1 out_a", int'(out_a), 0);
    chk("R1 out_b", int'(out_b), 0);
    rd(3'd0, v); chk("R1 mode", v, 0);
    rd(3'd3, v); chk("R1 period", v, 0);
    repeat (5) @(negedge clk);
    chk("R1 clock stopped", int'(bus_rdata), 0);

    // R10 readback
    wr(3'd0, 16'hA5C3); wr(3'd1, 16'h1234); wr(3'd2, 16'hFEDC); wr(3'd3, 16'h0F0F);
    rd(3'd0, v); chk("R10 mode", v, 16'hA5C3);
    rd(3'd1, v); chk("R10 cmpa", v, 16'h1234);
    rd(3'd2, v); chk("R10 cmpb", v, 16'hFEDC);
    rd(3'd3, v); chk("R10 period", v, 16'h0F0F);
    rd(3'd4, v); chk("R10 cmd reads 0", v, 0);

    // R11 / R2 / R3 / R5 sweep: A normal, B inverted
    for (int d = 0; d < 4; d++) begin
      for (int ri = 0; ri < 2; ri++) begin
        int rc, n;
        rc = (ri == 0) ? 2 : 5;
        n  = 2 << (2 * d);
        for (int ra = 0; ra < rc; ra++) begin
          wr(3'd3, rc); wr(3'd1, ra); wr(3'd2, ra);
          wr(3'd0, mode_word(d, 2, 1, 1, 1, 2, 2));
          wr(3'd4, 5); // enable + trigger
          for (int m = 0; m < 2 * (rc + 1) * n; m++) begin
            int c;
            @(negedge clk);
            c = (m / n) % (rc + 1);
            chk("R2/R3/R5 count", int'(bus_rdata), c);
            chk("R11 out_a normal", int'(out_a), (c <= ra) ? 1 : 0);
            chk("R11 out_b inverted", int'(out_b), (c <= ra) ? 0 : 1);
          end
        end
      end
    end

    // R5 trigger mid-run zeroes the count
    wr(3'd3, 100); wr(3'd0, mode_word(0, 0, 0, 1, 0, 0, 2));
    wr(3'd4, 5);
    repeat (20) @(negedge clk);
    wr(3'd4, 4);
    @(negedge clk);
    chk("R5 count zeroed", int'(bus_rdata), 0);
    chk("R5 sw set A", int'(out_a), 1);
    chk("R5 sw clear B", int'(out_b), 0);

    // R4 toggle encoding
    wr(3'd0, mode_word(0, 0, 0, 3, 0, 0, 3));
    @(negedge clk); hold_a = out_a; hold_b = out_b;
    wr(3'd4, 4); @(negedge clk);
    chk("R4 toggle A", int'(out_a), 1 - hold_a);
    chk("R4 toggle B", int'(out_b), 1 - hold_b);
    wr(3'd4, 4); @(negedge clk);
    chk("R4 toggle A back", int'(out_a), hold_a);

    // R6 none actions hold
    wr(3'd3, 3); wr(3'd1, 1); wr(3'd2, 2);
    wr(3'd0, mode_word(0, 0, 0, 1, 0, 0, 0));
    @(negedge clk); prev_b = out_b;
    wr(3'd4, 5);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R6 A held", int'(out_a), 1);
      chk("R6 B held", int'(out_b), prev_b);
    end

    // R9 compare == period, period action last
    wr(3'd3, 3); wr(3'd1, 3);
    wr(3'd0, mode_word(0, 1, 2, 1, 0, 0, 0));
    wr(3'd4, 5);
    for (int m = 0; m < 9; m++) begin
      @(negedge clk);
      if (m == 7) chk("R9 before collision", int'(out_a), 1);
      if (m == 8) chk("R9 period clear last", int'(out_a), 0);
    end

    // R7 disable holds count and outputs
    wr(3'd3, 100); wr(3'd1, 4);
    wr(3'd0, mode_word(0, 3, 0, 1, 3, 0, 2));
    wr(3'd4, 5);
    repeat (20) @(negedge clk);
    wr(3'd4, 2);
    @(negedge clk);
    hold_c = int'(bus_rdata); hold_a = out_a; hold_b = out_b;
    repeat (50) @(negedge clk);
    chk("R7 count held", int'(bus_rdata), hold_c);
    chk("R7 out_a held", int'(out_a), hold_a);
    chk("R7 out_b held", int'(out_b), hold_b);
    wr(3'd4, 1);
    repeat (10) @(negedge clk);
    chk("R7 re-enable counts", (int'(bus_rdata) > hold_c) ? 1 : 0, 1);

    // R8 enable and disable together: stopped
    wr(3'd4, 7);
    repeat (30) @(negedge clk);
    chk("R8 disable wins", int'(bus_rdata), 0);

    // R2 slow strobe
    wr(3'd3, 20); wr(3'd0, mode_word(4, 0, 0, 0, 0, 0, 0));
    wr(3'd4, 5);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
      repeat (3) @(negedge clk);
    end
    chk("R2 slow count", int'(bus_rdata), 5);
    // R2 code 5 never counts
    wr(3'd0, mode_word(5, 0, 0, 0, 0, 0, 0));
    wr(3'd4, 5);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
    end
    repeat (140) @(negedge clk);
    chk("R2 code 5 stopped", int'(bus_rdata), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule